// File: doc/BRIEF.md
# External Program Memory Fetch Controller

This block stands between a processor core and an 8-bit multiplexed address/data bus that serves an external code ROM and an external data RAM. The core asks for a code byte by presenting a 16-bit program counter. The block compares that counter with the size of the on-chip code store. A low address is served from the on-chip array. Any other address triggers an external bus cycle. The returned byte comes back together with the incremented counter.

An external cycle takes two states. In the first state the address latch strobe is high, the high address byte is on its own port, and the low byte is driven on the shared bus. In the second state the latch strobe is low and the active-low program-store strobe reads the byte. The core can also read or write external RAM through a 16-bit data pointer. These accesses use the same latch phase, followed by an active-low read or write strobe, under the RAM chip select.

The core interface is a request/valid handshake. A request is accepted only while `busy` is low. A one-cycle `rsp_valid` pulse closes every access.

Top module: `xmem_fetch_ctrl`

## Requirements
- R1: After reset, and whenever `busy` is low: `ale` is 0; `psen_n`, `rd_n`, `wr_n`, `cs_rom_n` and `cs_ram_n` are 1; `ad_oe` is 0; `rsp_valid` is 0 except in its pulse cycle.
- R2: A code fetch with `fetch_pc` below 0x1000 uses the on-chip store. In the cycle after acceptance, `irom_addr` equals `fetch_pc[11:0]` and no external strobe or chip select moves. In the next cycle, `rsp_valid` is 1 and `rsp_data` holds the on-chip byte that was read.
- R3: A code fetch with `fetch_pc` in the range 0x1000..0xFFFF starts with a latch cycle, which is the first cycle after acceptance. In that cycle `ale`=1, `hi_addr`=`fetch_pc[15:8]`, `ad_out`=`fetch_pc[7:0]`, `ad_oe`=1 and `cs_rom_n`=0.
- R4: The cycle after the code latch cycle has `ale`=0, `psen_n`=0, `ad_oe`=0 (bus released), and `cs_rom_n` still 0.
- R5: The byte on `ad_in` at the end of the strobe cycle is returned on `rsp_data`. In that return cycle `rsp_valid` is 1 for exactly one cycle and `psen_n` is back at 1. After any code fetch, `next_pc` equals the fetched address plus one, modulo 2^16.
- R6: `rd_n` and `wr_n` stay 1 throughout a code fetch, and `psen_n` stays 1 throughout a data access.
- R7: A data write runs in three cycles. First comes a latch cycle with `ale`=1, `cs_ram_n`=0 and the pointer on `hi_addr`/`ad_out`. Next comes a cycle with `wr_n`=0, `ad_oe`=1, `ad_out`=write data and `cs_ram_n`=0. Last comes a `rsp_valid` pulse.
- R8: A data read has the same latch cycle as R7. It is followed by a cycle with `rd_n`=0, `ad_oe`=0 and `cs_ram_n`=0. The byte on `ad_in` at the end of that cycle is returned with `rsp_valid`.
- R9: `cs_rom_n` and `cs_ram_n` are never 0 in the same cycle.
- R10: Requests are sampled only while `busy` is low. A request held during a busy access starts no extra bus cycle.
- R11: If a code and a data request are both present while idle, the code fetch is served. Data accesses leave `next_pc` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Code fetch request |
| fetch_pc | input | 16 | Program counter to fetch from |
| data_req | input | 1 | External data access request |
| data_we | input | 1 | 1 = write, 0 = read |
| data_ptr | input | 16 | Data pointer for external RAM |
| data_wdata | input | 8 | Write data |
| busy | output | 1 | Access in progress; requests ignored |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Fetched or read byte |
| next_pc | output | 16 | Fetched address plus one |
| irom_addr | output | 12 | On-chip code store address |
| irom_rdata | input | 8 | On-chip code store data (same cycle) |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| cs_rom_n | output | 1 | External ROM select, active low |
| cs_ram_n | output | 1 | External RAM select, active low |
| hi_addr | output | 8 | High address byte port |
| ad_out | output | 8 | Shared bus value when driven |
| ad_oe | output | 1 | Shared bus drive enable |
| ad_in | input | 8 | Shared bus value when released |

## Verification
The hardest case to reach is a request that arrives while another access is still running. The bench holds `data_req` high through the whole external fetch window. It then checks that the bus stays quiet once that fetch returns. It also presents code and data requests in the same idle cycle, so the arbitration decision is visible on the chip selects. The fetches are placed on the 0x0FFF/0x1000 boundary and at 0xFFFF. This exercises the split decision from both sides and the counter wrap.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_INT  = 3'd1,
    ST_CALE = 3'd2,
    ST_CSTB = 3'd3,
    ST_DALE = 3'd4,
    ST_DRD  = 3'd5,
    ST_DWR  = 3'd6
  } xst_t;
endpackage

// File: rtl/xmem_region.sv
module xmem_region #(
  parameter int ADDR_W     = 16,
  parameter int IROM_BYTES = 4096
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_int
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(IROM_BYTES);

  always_comb begin
    is_int = ({1'b0, addr} < LIMIT);
  end
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_req,
  input  logic data_req,
  input  logic data_we,
  input  logic is_int,
  output xst_t state_q,
  output xst_t state_d,
  output logic acc_fetch,
  output logic acc_data,
  output logic done
);
  logic we_q, we_d;

  always_comb begin
    state_d   = state_q;
    we_d      = we_q;
    acc_fetch = 1'b0;
    acc_data  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fetch_req) begin
          acc_fetch = 1'b1;
          state_d   = is_int ? ST_INT : ST_CALE;
        end else if (data_req) begin
          acc_data = 1'b1;
          we_d     = data_we;
          state_d  = ST_DALE;
        end
      end
      ST_CALE: state_d = ST_CSTB;
      ST_DALE: state_d = we_q ? ST_DWR : ST_DRD;
      ST_INT, ST_CSTB, ST_DRD, ST_DWR: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    done = (state_q == ST_INT) || (state_q == ST_CSTB) ||
           (state_q == ST_DRD) || (state_q == ST_DWR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      we_q    <= we_d;
    end
  end
endmodule

// File: rtl/xmem_pins.sv
module xmem_pins
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xst_t              state_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [DATA_W-1:0] wdata,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              cs_rom_n,
  output logic              cs_ram_n,
  output logic [ADDR_W-DATA_W-1:0] hi_addr,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic              ale_d, psen_d, rd_d, wr_d, csr_d, csm_d, oe_d;
  logic              hi_en, ad_en;
  logic [HI_W-1:0]   hi_d;
  logic [DATA_W-1:0] ad_d;

  always_comb begin
    ale_d  = (state_d == ST_CALE) || (state_d == ST_DALE);
    psen_d = (state_d != ST_CSTB);
    rd_d   = (state_d != ST_DRD);
    wr_d   = (state_d != ST_DWR);
    csr_d  = !((state_d == ST_CALE) || (state_d == ST_CSTB));
    csm_d  = !((state_d == ST_DALE) || (state_d == ST_DRD) || (state_d == ST_DWR));
    oe_d   = ale_d || (state_d == ST_DWR);
    hi_en  = ale_d;
    hi_d   = addr_d[ADDR_W-1:DATA_W];
    ad_en  = oe_d;
    ad_d   = ale_d ? addr_d[DATA_W-1:0] : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale      <= 1'b0;
      psen_n   <= 1'b1;
      rd_n     <= 1'b1;
      wr_n     <= 1'b1;
      cs_rom_n <= 1'b1;
      cs_ram_n <= 1'b1;
      ad_oe    <= 1'b0;
    end else begin
      ale      <= ale_d;
      psen_n   <= psen_d;
      rd_n     <= rd_d;
      wr_n     <= wr_d;
      cs_rom_n <= csr_d;
      cs_ram_n <= csm_d;
      ad_oe    <= oe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_addr <= '0;
    end else if (hi_en) begin
      hi_addr <= hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ad_out <= '0;
    end else if (ad_en) begin
      ad_out <= ad_d;
    end
  end
endmodule

// File: rtl/xmem_fetch_ctrl.sv
module xmem_fetch_ctrl
  import xmem_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int IROM_BYTES = 4096,
  localparam int IROM_AW   = $clog2(IROM_BYTES),
  localparam int HI_W      = ADDR_W - DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_req,
  input  logic [ADDR_W-1:0]  fetch_pc,
  input  logic               data_req,
  input  logic               data_we,
  input  logic [ADDR_W-1:0]  data_ptr,
  input  logic [DATA_W-1:0]  data_wdata,
  output logic               busy,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  output logic [ADDR_W-1:0]  next_pc,
  output logic [IROM_AW-1:0] irom_addr,
  input  logic [DATA_W-1:0]  irom_rdata,
  output logic               ale,
  output logic               psen_n,
  output logic               rd_n,
  output logic               wr_n,
  output logic               cs_rom_n,
  output logic               cs_ram_n,
  output logic [HI_W-1:0]    hi_addr,
  output logic [DATA_W-1:0]  ad_out,
  output logic               ad_oe,
  input  logic [DATA_W-1:0]  ad_in
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  xst_t              state_q, state_d;
  logic              acc_fetch, acc_data, done, is_int;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [DATA_W-1:0] cap_d;
  logic              cap_en, pc_en;

  xmem_region #(.ADDR_W(ADDR_W), .IROM_BYTES(IROM_BYTES)) u_region (
    .addr   (fetch_pc),
    .is_int (is_int)
  );

  xmem_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_req (fetch_req),
    .data_req  (data_req),
    .data_we   (data_we),
    .is_int    (is_int),
    .state_q   (state_q),
    .state_d   (state_d),
    .acc_fetch (acc_fetch),
    .acc_data  (acc_data),
    .done      (done)
  );

  always_comb begin
    if (acc_fetch)     addr_d = fetch_pc;
    else if (acc_data) addr_d = data_ptr;
    else               addr_d = addr_q;
    wdata_d = acc_data ? data_wdata : wdata_q;
    cap_en  = (state_q == ST_INT) || (state_q == ST_CSTB) || (state_q == ST_DRD);
    cap_d   = (state_q == ST_INT) ? irom_rdata : ad_in;
    pc_en   = (state_q == ST_INT) || (state_q == ST_CSTB);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_data <= '0;
    end else if (cap_en) begin
      rsp_data <= cap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_pc <= '0;
    end else if (pc_en) begin
      next_pc <= addr_q + ONE;
    end
  end

  always_comb begin
    busy      = (state_q != ST_IDLE);
    irom_addr = addr_q[IROM_AW-1:0];
  end

  xmem_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_d  (state_d),
    .addr_d   (addr_d),
    .wdata    (wdata_q),
    .ale      (ale),
    .psen_n   (psen_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .cs_rom_n (cs_rom_n),
    .cs_ram_n (cs_ram_n),
    .hi_addr  (hi_addr),
    .ad_out   (ad_out),
    .ad_oe    (ad_oe)
  );
endmodule

// File: rtl/xmem_fetch_ctrl_chk.sv
module xmem_fetch_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic rsp_valid,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic cs_rom_n,
  input logic cs_ram_n,
  input logic ad_oe
);
  // R9
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs_rom_n && !cs_ram_n));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ale && psen_n && rd_n && wr_n && cs_rom_n && cs_ram_n && !ad_oe));

  // R4
  latch_then_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!ale && (!psen_n || !rd_n || !wr_n)));

  // R6
  code_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> (rd_n && wr_n && !ad_oe && !cs_rom_n));

  // R8
  read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (!cs_ram_n && !ad_oe && wr_n && psen_n));

  // R7
  write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (!cs_ram_n && ad_oe && rd_n && psen_n));

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R5
  valid_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(busy) && !busy));
endmodule

bind xmem_fetch_ctrl xmem_fetch_ctrl_chk u_chk (.*);

// File: tb/xmem_fetch_ctrl_test.sv
`timescale 1ns/1ps
module xmem_fetch_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req = 1'b0;
  logic [15:0] fetch_pc = '0;
  logic        data_req = 1'b0;
  logic        data_we = 1'b0;
  logic [15:0] data_ptr = '0;
  logic [7:0]  data_wdata = '0;
  logic        busy, rsp_valid;
  logic [7:0]  rsp_data;
  logic [15:0] next_pc;
  logic [11:0] irom_addr;
  logic [7:0]  irom_rdata;
  logic        ale, psen_n, rd_n, wr_n, cs_rom_n, cs_ram_n, ad_oe;
  logic [7:0]  hi_addr, ad_out, ad_in;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  xmem_fetch_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .fetch_req(fetch_req), .fetch_pc(fetch_pc),
    .data_req(data_req), .data_we(data_we), .data_ptr(data_ptr), .data_wdata(data_wdata),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .next_pc(next_pc),
    .irom_addr(irom_addr), .irom_rdata(irom_rdata),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .cs_rom_n(cs_rom_n), .cs_ram_n(cs_ram_n),
    .hi_addr(hi_addr), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
  );

  function automatic logic [7:0] irom_f(input logic [11:0] a);
    return a[7:0] + {4'h0, a[11:8]} + 8'h11;
  endfunction
  function automatic logic [7:0] xrom_f(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // external devices
  logic [7:0] lat_lo = '0;
  logic [7:0] ram [0:255];
  always @(posedge clk) begin
    if (ale) lat_lo <= ad_out;
    if (!wr_n && !cs_ram_n) ram[lat_lo] <= ad_out;
  end
  always_comb irom_rdata = irom_f(irom_addr);
  always_comb begin
    if (!psen_n && !cs_rom_n)     ad_in = xrom_f({hi_addr, lat_lo});
    else if (!rd_n && !cs_ram_n)  ad_in = ram[lat_lo];
    else                          ad_in = 8'hEE;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(!ale && psen_n && rd_n && wr_n, "R1 strobes idle", {ale, psen_n, rd_n, wr_n}, 4'b0111);
    chk(cs_rom_n && cs_ram_n && !ad_oe, "R1 selects idle", {cs_rom_n, cs_ram_n, ad_oe}, 3'b110);
    chk(!busy && !rsp_valid, "R1 handshake idle", {busy, rsp_valid}, 2'b00);
  endtask

  task automatic t_int_fetch(input logic [15:0] pc);
    @(negedge clk); fetch_req = 1'b1; fetch_pc = pc;
    @(negedge clk); fetch_req = 1'b0;
    chk(busy && irom_addr == pc[11:0], "R2 irom addr", irom_addr, pc[11:0]);
    chk(!ale && psen_n && cs_rom_n && cs_ram_n, "R2 no ext strobe",
        {ale, psen_n, cs_rom_n, cs_ram_n}, 4'b0111);
    @(negedge clk);
    chk(rsp_valid && rsp_data == irom_f(pc[11:0]), "R2 int data", rsp_data, irom_f(pc[11:0]));
    chk(next_pc == pc + 16'd1, "R5 int next_pc", next_pc, pc + 16'd1);
    @(negedge clk);
    chk(!rsp_valid, "R5 single pulse", rsp_valid, 0);
  endtask

  task automatic t_ext_fetch(input logic [15:0] pc);
    @(negedge clk); fetch_req = 1'b1; fetch_pc = pc;
    @(negedge clk); fetch_req = 1'b0;
    chk(ale && ad_oe && !cs_rom_n && cs_ram_n, "R3 latch phase",
        {ale, ad_oe, cs_rom_n, cs_ram_n}, 4'b1101);
    chk({hi_addr, ad_out} == pc, "R3 address out", {hi_addr, ad_out}, pc);
    chk(psen_n && rd_n && wr_n, "R6 latch strobes", {psen_n, rd_n, wr_n}, 3'b111);
    @(negedge clk);
    chk(!ale && !psen_n && !ad_oe && !cs_rom_n, "R4 strobe phase",
        {ale, psen_n, ad_oe, cs_rom_n}, 4'b0000);
    chk(rd_n && wr_n, "R6 rd/wr high in fetch", {rd_n, wr_n}, 2'b11);
    @(negedge clk);
    chk(rsp_valid && rsp_data == xrom_f(pc), "R5 ext data", rsp_data, xrom_f(pc));
    chk(psen_n && cs_rom_n && !busy, "R5 psen released", {psen_n, cs_rom_n, busy}, 3'b110);
    chk(next_pc == pc + 16'd1, "R5 ext next_pc", next_pc, pc + 16'd1);
    @(negedge clk);
    chk(!rsp_valid, "R5 single pulse", rsp_valid, 0);
  endtask

  task automatic t_write(input logic [15:0] ptr, input logic [7:0] d);
    logic [15:0] pc_before;
    pc_before = next_pc;
    @(negedge clk); data_req = 1'b1; data_we = 1'b1; data_ptr = ptr; data_wdata = d;
    @(negedge clk); data_req = 1'b0;
    chk(ale && ad_oe && !cs_ram_n && cs_rom_n && {hi_addr, ad_out} == ptr,
        "R7 write latch", {hi_addr, ad_out}, ptr);
    @(negedge clk);
    chk(!wr_n && ad_oe && ad_out == d && !cs_ram_n && psen_n, "R7 write strobe", ad_out, d);
    chk(psen_n, "R6 psen high in data", psen_n, 1);
    @(negedge clk);
    chk(rsp_valid && wr_n && cs_ram_n, "R7 write done", {rsp_valid, wr_n, cs_ram_n}, 3'b111);
    chk(next_pc == pc_before, "R11 next_pc kept", next_pc, pc_before);
  endtask

  task automatic t_read(input logic [15:0] ptr, input logic [7:0] expv);
    @(negedge clk); data_req = 1'b1; data_we = 1'b0; data_ptr = ptr;
    @(negedge clk); data_req = 1'b0;
    chk(ale && !cs_ram_n && {hi_addr, ad_out} == ptr, "R8 read latch", {hi_addr, ad_out}, ptr);
    @(negedge clk);
    chk(!rd_n && !ad_oe && !cs_ram_n && wr_n && psen_n, "R8 read strobe",
        {rd_n, ad_oe, cs_ram_n}, 3'b000);
    @(negedge clk);
    chk(rsp_valid && rsp_data == expv, "R8 read data", rsp_data, expv);
  endtask

  task automatic t_busy_ignore();
    @(negedge clk); fetch_req = 1'b1; fetch_pc = 16'h2345;
    data_req = 1'b1; data_we = 1'b1; data_ptr = 16'h0077; data_wdata = 8'h99;
    @(negedge clk); fetch_req = 1'b0;
    chk(!cs_rom_n && cs_ram_n, "R11 code wins", {cs_rom_n, cs_ram_n}, 2'b01);
    @(negedge clk);
    @(negedge clk); data_req = 1'b0;
    chk(rsp_valid && rsp_data == xrom_f(16'h2345), "R11 fetch served", rsp_data, xrom_f(16'h2345));
    // data_req was held over the busy window and dropped before idle sampling
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!ale && cs_ram_n && !busy, "R10 held req ignored", {ale, cs_ram_n, busy}, 3'b010);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_int_fetch(16'h0000);
    t_int_fetch(16'h0FFF);
    t_ext_fetch(16'h1000);
    t_ext_fetch(16'hA5C3);
    t_ext_fetch(16'hFFFF);
    t_write(16'h4312, 8'h6B);
    t_write(16'h8055, 8'hC4);
    t_read(16'h4312, 8'h6B);
    t_read(16'h8055, 8'hC4);
    t_busy_ignore();
    t_read(16'h0077, ram[8'h77]);
    @(negedge clk);
    t_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule